// File: doc/BRIEF.md
# Pre/Post-Trigger Capture Controller

This block steers sample storage for a small logic analyzer. Once armed, it writes each accepted 32-bit sample, one bit per channel, into a circular sample memory at consecutive addresses, wrapping at the memory depth. A host-selected split divides the memory into a pre-trigger region and a post-trigger region in coarse blocks (8K samples at the default depth of 128K). The trigger input is refused until the pre-trigger region has been filled since the arm. After an accepted trigger, the block writes exactly the post-trigger quota of further samples, stops writing and raises a done flag. It also reports the wrap-adjusted address of the oldest kept sample, so the host can read the buffer back in time order.

The controller is a five-state machine. IDLE is the state after reset, with no writes. FILL writes samples until the pre-trigger quota is met, and ignores the trigger. HUNT keeps writing and waits for the trigger. POST writes the post-trigger quota. DONE holds the result with writes stopped. The transitions are as follows. ARM (any state to FILL, or to HUNT when the pre-trigger size is zero). FILLED (FILL to HUNT on the write that meets the quota). TRIGGERED (HUNT to POST). TRIGGERED_FULL (HUNT to DONE when the post-trigger quota is zero). LAST_WRITE (POST to DONE on the final post-trigger write). Arm takes priority over every other transition. Trigger detection, the timebase and readout transport are outside this block.

Top module: `cap_ctl`

## Requirements
- R1: After reset, `cap_done` is 0 and `mem_we` is 0, even with `smp_stb` and `trig` high.
- R2: In a cycle with `arm` high no write happens. From the next cycle, `cap_done` is 0 and the next write goes to address 0. `split_sel` is sampled in the `arm` cycle.
- R3: In FILL, HUNT and POST, each cycle with `smp_stb` high drives `mem_we` high with `mem_wdata` equal to `smp_data` at `mem_addr`. The address then advances by one, modulo 2^ADDR_W. A cycle without `smp_stb` does not write.
- R4: A `split_sel` value of n gives a pre-trigger size of n*2^BLK_LOG2 samples. `trig` is ignored until that many samples have been written since the arm, including on the write that completes the count.
- R5: After an accepted trigger, exactly 2^ADDR_W minus the pre-trigger size further samples are written. `cap_done` rises in the cycle after the last of them, and writing stops. A sample strobed in the same cycle as the accepted trigger counts as pre-trigger.
- R6: `start_ptr` equals the trigger address minus the pre-trigger size, modulo 2^ADDR_W. The trigger address is the address of the first post-trigger sample.
- R7: With a pre-trigger size of the full depth, an accepted trigger raises `cap_done` in the next cycle with no further write, and `start_ptr` equals the trigger address.
- R8: A new `arm` restarts capture from any state, including mid-capture. `trig` in IDLE or DONE has no effect: `cap_done` and `start_ptr` hold.
- R9: A `split_sel` value above 2^(ADDR_W-BLK_LOG2) is treated as that maximum, which means the full depth is pre-trigger.
- R10: In IDLE and DONE, `smp_stb` produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| arm | input | 1 | Start or restart capture, one-cycle command |
| split_sel | input | SEL_W (5) | Pre-trigger size in blocks, 0 to 2^(ADDR_W-BLK_LOG2) |
| trig | input | 1 | Trigger event pulse |
| smp_stb | input | 1 | Sample-enable strobe |
| smp_data | input | SAMPLE_W | Sample word, one bit per channel |
| mem_we | output | 1 | Sample memory write enable |
| mem_addr | output | ADDR_W | Sample memory write address |
| mem_wdata | output | SAMPLE_W | Sample memory write data |
| cap_done | output | 1 | Capture finished, memory holds a complete record |
| start_ptr | output | ADDR_W | Address of the oldest kept sample |

## Verification
A corrupted shared quota counter shows at the ports as `cap_done` rising after the wrong number of post-trigger writes, or as a trigger being accepted early. The bench counts writes between the trigger and `cap_done` exactly, so either fault appears by the end of that capture. A wrong write pointer shows in the first write after the fault, because every strobed cycle compares `mem_addr` with an independent count. The same pointer fault also shows in `start_ptr` when the capture ends. State stuck in DONE or IDLE shows as missing writes on the next strobe.

// File: rtl/capctl_pkg.sv
package capctl_pkg;
    typedef enum logic [2:0] {
        CS_IDLE,
        CS_FILL,
        CS_HUNT,
        CS_POST,
        CS_DONE
    } cap_state_e;
endpackage

// File: rtl/cap_split.sv
// Decodes and holds the pre/post-trigger split, sampled at arm.
module cap_split #(
    parameter int ADDR_W   = 17,
    parameter int BLK_LOG2 = 13,
    localparam int NBLK    = 1 << (ADDR_W - BLK_LOG2),
    localparam int SEL_W   = $clog2(NBLK + 1),
    localparam int LEN_W   = ADDR_W + 1,
    localparam int DEPTH   = 1 << ADDR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] sel,
    output logic [LEN_W-1:0] pre_next,
    output logic [LEN_W-1:0] post_len,
    output logic [ADDR_W-1:0] pre_ofs
);
    logic [SEL_W-1:0] sel_c;
    logic [LEN_W-1:0] pre_len;

    always_comb begin
        sel_c    = (sel > SEL_W'(NBLK)) ? SEL_W'(NBLK) : sel;
        pre_next = LEN_W'(sel_c) << BLK_LOG2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_len <= '0;
        else if (load) pre_len <= pre_next;
    end

    assign post_len = LEN_W'(DEPTH) - pre_len;
    assign pre_ofs  = pre_len[ADDR_W-1:0];

    p_pre_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pre_len <= LEN_W'(DEPTH));
endmodule

// File: rtl/cap_wptr.sv
// Circular write pointer.
module cap_wptr #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              inc,
    output logic [ADDR_W-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ptr <= '0;
        else if (clear) ptr <= '0;
        else if (inc)   ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/cap_cnt.sv
// Shared down-counter for the fill quota and the post-trigger quota.
module cap_cnt #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_one
);
    logic [W-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    left <= '0;
        else if (load) left <= load_val;
        else if (dec)  left <= left - 1'b1;
    end

    assign is_one = (left == W'(1));

    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (left != '0));
endmodule

// File: rtl/cap_ctl.sv
// Pre/post-trigger capture controller: top level and state machine.
module cap_ctl
    import capctl_pkg::*;
#(
    parameter int SAMPLE_W = 32,
    parameter int ADDR_W   = 17,
    parameter int BLK_LOG2 = 13,
    localparam int NBLK    = 1 << (ADDR_W - BLK_LOG2),
    localparam int SEL_W   = $clog2(NBLK + 1),
    localparam int LEN_W   = ADDR_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arm,
    input  logic [SEL_W-1:0]    split_sel,
    input  logic                trig,
    input  logic                smp_stb,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [SAMPLE_W-1:0] mem_wdata,
    output logic                cap_done,
    output logic [ADDR_W-1:0]   start_ptr
);
    cap_state_e state, state_n;

    logic [LEN_W-1:0]  pre_next, post_len, cnt_val;
    logic [ADDR_W-1:0] pre_ofs, wptr;
    logic              cnt_load, cnt_dec, cnt_one, start_cap, capturing;

    cap_split #(.ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2)) i_split (
        .clk(clk), .rst_n(rst_n), .load(arm), .sel(split_sel),
        .pre_next(pre_next), .post_len(post_len), .pre_ofs(pre_ofs)
    );

    cap_wptr #(.ADDR_W(ADDR_W)) i_wptr (
        .clk(clk), .rst_n(rst_n), .clear(arm), .inc(mem_we), .ptr(wptr)
    );

    cap_cnt #(.W(LEN_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
        .dec(cnt_dec), .is_one(cnt_one)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CS_IDLE;
        else        state <= state_n;
    end

    // Transitions: ARM, FILLED, TRIGGERED, TRIGGERED_FULL, LAST_WRITE
    always_comb begin
        state_n = state;
        if (arm) begin
            state_n = (pre_next == '0) ? CS_HUNT : CS_FILL;
        end else begin
            unique case (state)
                CS_IDLE: state_n = CS_IDLE;
                CS_FILL: if (smp_stb && cnt_one) state_n = CS_HUNT;
                CS_HUNT: if (trig) state_n = (post_len == '0) ? CS_DONE : CS_POST;
                CS_POST: if (smp_stb && cnt_one) state_n = CS_DONE;
                CS_DONE: state_n = CS_DONE;
            endcase
        end
    end

    // Outputs and datapath controls
    always_comb begin
        capturing = (state == CS_FILL) || (state == CS_HUNT) || (state == CS_POST);
        mem_we    = capturing && smp_stb && !arm;
        mem_addr  = wptr;
        mem_wdata = smp_data;
        start_cap = (state == CS_HUNT) && trig && !arm;
        cnt_load  = arm || start_cap;
        cnt_val   = arm ? pre_next : post_len;
        cnt_dec   = mem_we && ((state == CS_FILL) || (state == CS_POST));
        cap_done  = (state == CS_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         start_ptr <= '0;
        else if (start_cap) start_ptr <= wptr + ADDR_W'(smp_stb) - pre_ofs;
    end

    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done |-> !mem_we);
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (mem_addr == $past(mem_addr) + 1'b1));
    p_arm_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (!cap_done && mem_addr == '0));
    p_fill_no_post_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CS_FILL) |=> (state != CS_POST));
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_done && !arm) |=> (cap_done && $stable(start_ptr)));
    p_full_pre_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_cap && post_len == '0) |=> cap_done);
endmodule

// File: tb/test_cap_ctl.sv
module test_cap_ctl;
    localparam int AW    = 7;
    localparam int BL    = 3;
    localparam int SW    = 32;
    localparam int DEPTH = 1 << AW;
    localparam int NBLK  = DEPTH >> BL;
    localparam int SELW  = $clog2(NBLK + 1);

    logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, trig = 1'b0, stb = 1'b0;
    logic [SELW-1:0] sel = '0;
    logic [SW-1:0]   data = '0;
    logic            mem_we, cap_done;
    logic [AW-1:0]   mem_addr, start_ptr;
    logic [SW-1:0]   mem_wdata;

    cap_ctl #(.SAMPLE_W(SW), .ADDR_W(AW), .BLK_LOG2(BL)) i_cap_ctl (
        .clk(clk), .rst_n(rst_n), .arm(arm), .split_sel(sel), .trig(trig),
        .smp_stb(stb), .smp_data(data), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .cap_done(cap_done), .start_ptr(start_ptr)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0, cur_pre = 0;
    bit finished = 0;
    logic [AW-1:0] exp_addr = '0, trig_addr = '0, exp_start = '0;

    task automatic chk(input string tag, input longint act, input longint expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic do_arm(input int s);
        @(negedge clk); arm = 1; sel = SELW'(s); stb = 1; trig = 1;
        #1 chk("R2 no write in arm cycle", mem_we, 0);
        @(negedge clk); arm = 0; stb = 0; trig = 0;
        #1 chk("R2 done cleared by arm", cap_done, 0);
        exp_addr = '0;
        cur_pre = ((s > NBLK) ? NBLK : s) * (1 << BL);
    endtask

    task automatic write_n(input int n, input bit t);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); stb = 1; trig = t;
            data = 32'hC0DE_0000 ^ (k * 32'h0001_0307) ^ {25'd0, exp_addr};
            #1;
            chk("R3 write enable", mem_we, 1);
            chk("R3 write address", mem_addr, exp_addr);
            chk("R3 write data", mem_wdata, data);
            chk("R4 early trigger ignored", cap_done, 0);
            exp_addr = exp_addr + 1'b1;
        end
    endtask

    task automatic fire(input bit s);
        @(negedge clk); trig = 1; stb = s;
        #1 if (s) chk("R3 address at trigger", mem_addr, exp_addr);
        exp_addr  = exp_addr + AW'(s);
        trig_addr = exp_addr;
        exp_start = trig_addr - AW'(cur_pre);
    endtask

    task automatic drain(input int exp_post);
        int cnt = 0;
        for (int k = 0; k < 4 * DEPTH; k++) begin
            @(negedge clk); trig = (k == 3); stb = 0;
            if (cap_done) break;
            stb = (k % 3 != 2);
            #1;
            if (stb) begin
                chk("R3 post write address", mem_addr, exp_addr);
                chk("R3 post write enable", mem_we, 1);
                cnt++;
                exp_addr = exp_addr + 1'b1;
            end else begin
                chk("R3 no write without strobe", mem_we, 0);
            end
        end
        trig = 0;
        chk("R5 post-trigger write count", cnt, exp_post);
        chk("R5 done raised", cap_done, 1);
        chk("R6 start pointer", start_ptr, exp_start);
    endtask

    task automatic poke_done();
        @(negedge clk); stb = 1; trig = 1;
        #1 chk("R10 no write while done", mem_we, 0);
        @(negedge clk); stb = 0; trig = 0;
        #1 chk("R8 done holds after trigger", cap_done, 1);
        chk("R8 start pointer holds", start_ptr, exp_start);
    endtask

    task automatic t_reset();
        stb = 1; trig = 1;
        repeat (3) @(negedge clk);
        #1 chk("R1 done low in reset", cap_done, 0);
        chk("R1 no write in reset", mem_we, 0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        #1 chk("R10 no write in idle", mem_we, 0);
        chk("R8 trigger in idle ignored", cap_done, 0);
        @(negedge clk); stb = 0; trig = 0;
    endtask

    task automatic t_wrap_split();
        do_arm(4);
        write_n(32, 1);
        write_n(98, 0);
        fire(1);
        drain(DEPTH - 32);
        poke_done();
    endtask

    task automatic t_zero_pre();
        do_arm(0);
        fire(0);
        drain(DEPTH);
        chk("R4 zero pre start", start_ptr, 0);
    endtask

    task automatic t_full_pre();
        do_arm(NBLK);
        write_n(DEPTH, 1);
        fire(0);
        drain(0);
        chk("R7 full pre start equals trigger address", start_ptr, trig_addr);
    endtask

    task automatic t_clamp();
        do_arm(NBLK + 4);
        write_n(DEPTH, 1);
        fire(0);
        drain(0);
        chk("R9 clamped split acts as full", cap_done, 1);
    endtask

    task automatic t_rearm();
        do_arm(2);
        write_n(5, 0);
        do_arm(1);
        write_n(8, 1);
        fire(0);
        drain(DEPTH - 8);
        chk("R8 restart start pointer", start_ptr, 0);
    endtask

    initial begin
        t_reset();
        t_wrap_split();
        t_zero_pre();
        t_full_pre();
        t_clamp();
        t_rearm();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule